// File: doc/BRIEF.md
# ATA Task-File Address Translator

This block sits between a PC Card host port (common memory or I/O space) and an ATA task-file register set. A six-bit addressing mode chooses how each host address becomes a register offset from 0 to 15. The offset then decides whether the access goes out on the downstream task-file port, which offset that port sees, or whether the block answers the access itself.

Five registers are served locally. Alternate status returns the attached drive's status. Device control is stored in the block. The device-address read is built from the drive-select value. The odd data byte has a latch and a phase bit. All remaining offsets pass straight through, combinationally, in the same cycle as the host strobe.

Two side-band actions come with writes. A write to a forwarded task-file register while the card is in power-down raises wake pulses. A device-control write with the soft-reset bit set pulses a card reset.

Top module: `ata_tf_xlate`

## Requirements
- R1: In mode 0 (memory-mapped), any host address from 0x400 to 0x7FF gives offset 0, the data register.
- R2: In mode 1 (contiguous I/O), the offset is the host address ANDed with 0xF.
- R3: In mode 2 (primary), addresses 0x1F0..0x1FF give (address - 0x1F0), and addresses 0x3F0..0x3FF give (address - 0x3E8) modulo 16, so 0x3F6 gives 0xE and 0x3F7 gives 0xF.
- R4: In mode 3 (secondary), addresses 0x170..0x17F give (address - 0x170), and addresses 0x370..0x37F give (address - 0x368) modulo 16.
- R5: An address outside every recognised window, and any mode value above 3, gives the low four address bits as the offset.
- R6: Offsets 0 and 8 are sent downstream as offset 0, offset 0xD as offset 1, and any other offset not handled locally as itself. A forwarded access raises tf_rd or tf_wr in the same cycle as the host strobe, with tf_wdata equal to host_wdata and host_rdata equal to tf_rdata.
- R7: A read of offset 0xE returns the drive status in bits 7:0 when a drive is present and 0 otherwise, with no downstream strobe.
- R8: A read of offset 0xF returns 0xC2 OR ((inverted drive-select shifted left by 2) AND 0x3C): 0x00FE for select 0 and 0x00FA for select 1, with no downstream strobe.
- R9: A write to offset 0xE stores bits 7:0 in dev_ctrl from the next cycle on, with no downstream strobe.
- R10: A write to offset 0xE with bit 2 set pulses card_reset in that cycle. From the next cycle dev_ctrl, byte_latch and byte_phase are all 0.
- R11: A write to offset 0x9 stores bits 7:0 in byte_latch and toggles byte_phase, with no downstream strobe. A read of offset 0x9 returns 0 with no downstream strobe.
- R12: A write with pwrdn_flag high to a forwarded offset other than 0, 8 and 0xD pulses pwrdn_clr and rdy_set in the same cycle and is still forwarded. Writes to the data offsets and to 0xD raise no wake pulse.
- R13: After reset, dev_ctrl, byte_latch and byte_phase are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 6 | Addressing mode (0 memory, 1 contiguous I/O, 2 primary, 3 secondary) |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | DATA_W | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_rdata | output | DATA_W | Host read data |
| tf_off | output | 4 | Downstream task-file offset |
| tf_wdata | output | DATA_W | Downstream write data |
| tf_rd | output | 1 | Downstream read strobe |
| tf_wr | output | 1 | Downstream write strobe |
| tf_rdata | input | DATA_W | Downstream read data |
| drv_present | input | 1 | A drive is attached |
| drv_status | input | 8 | Status of the active drive |
| drv_sel | input | 1 | Drive-select value of the active drive |
| pwrdn_flag | input | 1 | Card power-down flag |
| pwrdn_clr | output | 1 | Pulse: clear power-down |
| rdy_set | output | 1 | Pulse: set the ready flag |
| dev_ctrl | output | 8 | Stored device-control value |
| card_reset | output | 1 | Pulse: soft reset requested |
| byte_latch | output | 8 | Latched odd-cycle low byte |
| byte_phase | output | 1 | Byte-cycle phase flag |

## Verification
The bench builds the block with its default parameters: an 11-bit host address and a 16-bit data path. With these the whole memory-mapped data window (0x400..0x7FF) can be reached, and so can both legacy window pairs. The high control windows fold onto 0xE and 0xF, and their upper halves wrap modulo 16 onto forwarded offsets. The narrow data path makes the drive-select pattern and the 8-bit latch and control fields easy to see directly on the ports.

// File: rtl/tf_xlate_pkg.sv
package tf_xlate_pkg;

    // Addressing modes, taken from the low six bits of the option register
    localparam logic [5:0] MAP_MEM  = 6'd0;
    localparam logic [5:0] MAP_IO16 = 6'd1;
    localparam logic [5:0] MAP_PRI  = 6'd2;
    localparam logic [5:0] MAP_SEC  = 6'd3;

    // 16-byte block numbers (address >> 4) of the legacy control windows
    localparam int unsigned PRI_CTL_BLK = 'h3F;
    localparam int unsigned SEC_CTL_BLK = 'h37;
    // Fold distance of a control window: subtract 0x3E8/0x368 == add 8 mod 16
    localparam logic [3:0]  CTL_FOLD    = 4'h8;

    // Internal offsets with local meaning
    localparam logic [3:0] OFF_DATA    = 4'h0;
    localparam logic [3:0] OFF_DATA_HI = 4'h8;
    localparam logic [3:0] OFF_ODD     = 4'h9;
    localparam logic [3:0] OFF_ERRFEAT = 4'hD;
    localparam logic [3:0] OFF_CTLSTAT = 4'hE;
    localparam logic [3:0] OFF_DEVADDR = 4'hF;
    localparam logic [3:0] TF_ERRFEAT  = 4'h1;

    localparam int unsigned SRST_BIT = 2;

    typedef struct packed {
        logic       fwd_rd;     // read goes downstream
        logic       fwd_wr;     // write goes downstream
        logic       wake;       // write of the wake class
        logic [3:0] tf_off;     // offset presented downstream
    } route_t;

    function automatic logic [7:0] devaddr_byte(input logic sel);
        logic [7:0] inv;
        inv = ~{7'b0, sel};
        return 8'hC2 | ((inv << 2) & 8'h3C);
    endfunction

endpackage

// File: rtl/tf_addr_map.sv
module tf_addr_map
    import tf_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic [5:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        off
);
    localparam int unsigned BLK_W = ADDR_W - 4;
    localparam int unsigned WIN_W = ADDR_W - 10;

    logic [BLK_W-1:0] blk;
    logic             in_mem_data;

    assign blk         = addr[ADDR_W-1:4];
    assign in_mem_data = (addr[ADDR_W-1:10] == WIN_W'(1));

    always_comb begin
        // command windows (0x1F0, 0x170) subtract their base: low nibble
        off = addr[3:0];
        case (mode)
            MAP_MEM:  if (in_mem_data) off = OFF_DATA;
            MAP_IO16: off = addr[3:0];
            MAP_PRI:  if (blk == BLK_W'(PRI_CTL_BLK)) off = addr[3:0] + CTL_FOLD;
            MAP_SEC:  if (blk == BLK_W'(SEC_CTL_BLK)) off = addr[3:0] + CTL_FOLD;
            default:  off = addr[3:0];
        endcase
    end
endmodule

// File: rtl/tf_route.sv
module tf_route
    import tf_xlate_pkg::*;
(
    input  logic [3:0] off,
    input  logic       pwrdn_flag,
    input  logic       wr,
    output route_t     rt
);
    always_comb begin
        rt.fwd_rd = !(off inside {OFF_ODD, OFF_CTLSTAT, OFF_DEVADDR});
        rt.fwd_wr = !(off inside {OFF_ODD, OFF_CTLSTAT});
        rt.wake   = wr && pwrdn_flag &&
                    !(off inside {OFF_DATA, OFF_DATA_HI, OFF_ODD, OFF_ERRFEAT, OFF_CTLSTAT});
        if (off == OFF_DATA || off == OFF_DATA_HI)
            rt.tf_off = OFF_DATA;
        else if (off == OFF_ERRFEAT)
            rt.tf_off = TF_ERRFEAT;
        else
            rt.tf_off = off;
    end
endmodule

// File: rtl/tf_local_regs.sv
module tf_local_regs
    import tf_xlate_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [3:0]        off,
    input  logic [7:0]        wbyte,
    input  logic [DATA_W-1:0] tf_rdata,
    input  logic              drv_present,
    input  logic [7:0]        drv_status,
    input  logic              drv_sel,
    output logic [DATA_W-1:0] rdata,
    output logic [7:0]        ctrl_q,
    output logic [7:0]        latch_q,
    output logic              phase_q,
    output logic              srst
);
    logic ctl_wr, odd_wr;

    assign ctl_wr = wr && (off == OFF_CTLSTAT);
    assign odd_wr = wr && (off == OFF_ODD);
    assign srst   = ctl_wr && wbyte[SRST_BIT];

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            ctrl_q  <= '0;
            latch_q <= '0;
            phase_q <= 1'b0;
        end else begin
            if (ctl_wr) ctrl_q <= wbyte;
            if (odd_wr) begin
                latch_q <= wbyte;
                phase_q <= !phase_q;
            end
        end
    end

    always_comb begin
        case (off)
            OFF_CTLSTAT: rdata = drv_present ? DATA_W'(drv_status) : '0;
            OFF_DEVADDR: rdata = DATA_W'(devaddr_byte(drv_sel));
            OFF_ODD:     rdata = '0;   // upper byte of a latch that holds a low byte only
            default:     rdata = tf_rdata;
        endcase
    end
endmodule

// File: rtl/ata_tf_xlate.sv
module ata_tf_xlate
    import tf_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        mode,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    input  logic              host_wr,
    output logic [DATA_W-1:0] host_rdata,
    output logic [3:0]        tf_off,
    output logic [DATA_W-1:0] tf_wdata,
    output logic              tf_rd,
    output logic              tf_wr,
    input  logic [DATA_W-1:0] tf_rdata,
    input  logic              drv_present,
    input  logic [7:0]        drv_status,
    input  logic              drv_sel,
    input  logic              pwrdn_flag,
    output logic              pwrdn_clr,
    output logic              rdy_set,
    output logic [7:0]        dev_ctrl,
    output logic              card_reset,
    output logic [7:0]        byte_latch,
    output logic              byte_phase
);
    logic [3:0] xl_off;
    route_t     rt;

    tf_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .mode (mode),
        .addr (host_addr),
        .off  (xl_off)
    );

    tf_route u_route (
        .off        (xl_off),
        .pwrdn_flag (pwrdn_flag),
        .wr         (host_wr),
        .rt         (rt)
    );

    tf_local_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (host_wr),
        .off         (xl_off),
        .wbyte       (host_wdata[7:0]),
        .tf_rdata    (tf_rdata),
        .drv_present (drv_present),
        .drv_status  (drv_status),
        .drv_sel     (drv_sel),
        .rdata       (host_rdata),
        .ctrl_q      (dev_ctrl),
        .latch_q     (byte_latch),
        .phase_q     (byte_phase),
        .srst        (card_reset)
    );

    assign tf_off    = rt.tf_off;
    assign tf_wdata  = host_wdata;
    assign tf_rd     = host_rd && rt.fwd_rd;
    assign tf_wr     = host_wr && rt.fwd_wr;
    assign pwrdn_clr = rt.wake;
    assign rdy_set   = rt.wake;
endmodule

// File: rtl/ata_tf_xlate_chk.sv
module ata_tf_xlate_chk #(
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [5:0]        mode,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rd,
    input logic              host_wr,
    input logic              tf_rd,
    input logic              tf_wr,
    input logic [3:0]        tf_off,
    input logic [3:0]        xl_off,
    input logic              pwrdn_flag,
    input logic              pwrdn_clr,
    input logic              rdy_set,
    input logic              card_reset,
    input logic [7:0]        dev_ctrl,
    input logic              byte_phase
);
    p_rd_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        tf_rd |-> host_rd);

    p_wr_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        tf_wr |-> host_wr);

    p_mem_window_r1: assert property (@(posedge clk) disable iff (rst)
        (host_rd && mode == 6'd0 && host_addr[ADDR_W-1:10] == (ADDR_W-10)'(1))
        |-> (tf_rd && tf_off == 4'h0));

    p_status_local_r7: assert property (@(posedge clk) disable iff (rst)
        (host_rd && xl_off == 4'hE) |-> !tf_rd);

    p_wake_pair_r12: assert property (@(posedge clk) disable iff (rst)
        pwrdn_clr |-> (rdy_set && tf_wr && pwrdn_flag));

    p_srst_clear_r10: assert property (@(posedge clk) disable iff (rst)
        card_reset |=> (dev_ctrl == 8'h00 && !byte_phase));

    p_phase_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !host_wr |=> $stable(byte_phase));
endmodule

bind ata_tf_xlate ata_tf_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .host_addr  (host_addr),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .tf_rd      (tf_rd),
    .tf_wr      (tf_wr),
    .tf_off     (tf_off),
    .xl_off     (xl_off),
    .pwrdn_flag (pwrdn_flag),
    .pwrdn_clr  (pwrdn_clr),
    .rdy_set    (rdy_set),
    .card_reset (card_reset),
    .dev_ctrl   (dev_ctrl),
    .byte_phase (byte_phase)
);

// File: tb/ata_tf_xlate_bench.sv
module ata_tf_xlate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [5:0]    mode = '0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_rd = 1'b0, host_wr = 1'b0;
    logic [DW-1:0] host_rdata;
    logic [3:0]    tf_off;
    logic [DW-1:0] tf_wdata;
    logic          tf_rd, tf_wr;
    logic [DW-1:0] tf_rdata = '0;
    logic          drv_present = 1'b0;
    logic [7:0]    drv_status = '0;
    logic          drv_sel = 1'b0;
    logic          pwrdn_flag = 1'b0;
    logic          pwrdn_clr, rdy_set, card_reset, byte_phase;
    logic [7:0]    dev_ctrl, byte_latch;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_tf_xlate #(.ADDR_W(AW), .DATA_W(DW)) u_ata_tf_xlate (.*);

    typedef struct packed {
        logic [5:0]    mode;
        logic [AW-1:0] addr;
        logic          fwd;
        logic [3:0]    exp_tf;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{6'd0, 11'h400, 1'b1, 4'h0},  // R1 window base
        '{6'd0, 11'h7FE, 1'b1, 4'h0},  // R1 window top
        '{6'd0, 11'h3F7, 1'b1, 4'h7},  // R5 outside window
        '{6'd0, 11'h00D, 1'b1, 4'h1},  // R6 0xD -> 1
        '{6'd1, 11'h2A5, 1'b1, 4'h5},  // R2
        '{6'd1, 11'h1F8, 1'b1, 4'h0},  // R2 / R6 data alias 8 -> 0
        '{6'd2, 11'h1F3, 1'b1, 4'h3},  // R3 command window
        '{6'd2, 11'h3F6, 1'b0, 4'h0},  // R3 folds to 0xE, local
        '{6'd2, 11'h3F1, 1'b0, 4'h0},  // R3 folds to 0x9, local
        '{6'd2, 11'h3FA, 1'b1, 4'h2},  // R3 wraps to 2
        '{6'd2, 11'h175, 1'b1, 4'h5},  // R5 secondary addr in primary mode
        '{6'd3, 11'h177, 1'b1, 4'h7},  // R4 command window
        '{6'd3, 11'h377, 1'b0, 4'h0},  // R4 folds to 0xF, local
        '{6'd3, 11'h37C, 1'b1, 4'h4},  // R4 wraps to 4
        '{6'd3, 11'h1F6, 1'b1, 4'h6},  // R5 primary addr in secondary mode
        '{6'd7, 11'h3F6, 1'b1, 4'h6},  // R5 undefined mode
        '{6'd4, 11'h40B, 1'b1, 4'hB}   // R5 undefined mode
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic rd, input logic wr, input logic [5:0] m,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        mode = m; host_addr = a; host_wdata = d; host_rd = rd; host_wr = wr;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R13 reset state
        check("R13 dev_ctrl", 32'(dev_ctrl), 32'h0);
        check("R13 byte_latch", 32'(byte_latch), 32'h0);
        check("R13 byte_phase", 32'(byte_phase), 32'h0);

        // table walk: reads in each mode
        for (int i = 0; i < NV; i++) begin
            tf_rdata = 16'hA5C3 ^ 16'(i);
            put(1'b1, 1'b0, VECS[i].mode, VECS[i].addr, '0);
            check($sformatf("R1-5 vec %0d tf_rd", i), 32'(tf_rd), 32'(VECS[i].fwd));
            if (VECS[i].fwd) begin
                check($sformatf("vec %0d tf_off", i), 32'(tf_off), 32'(VECS[i].exp_tf));
                check($sformatf("R6 vec %0d rdata", i), 32'(host_rdata), 32'(tf_rdata));
            end
            idle();
        end

        // R7 alternate status
        drv_present = 1'b1; drv_status = 8'h58;
        put(1'b1, 1'b0, 6'd1, 11'h00E, '0);
        check("R7 status present", 32'(host_rdata), 32'h0058);
        check("R7 no tf_rd", 32'(tf_rd), 32'h0);
        idle();
        drv_present = 1'b0;
        put(1'b1, 1'b0, 6'd2, 11'h3F6, '0);
        check("R7 status absent", 32'(host_rdata), 32'h0);
        idle();

        // R8 device address
        drv_sel = 1'b0;
        put(1'b1, 1'b0, 6'd1, 11'h00F, '0);
        check("R8 sel0", 32'(host_rdata), 32'h00FE);
        check("R8 no tf_rd", 32'(tf_rd), 32'h0);
        idle();
        drv_sel = 1'b1;
        put(1'b1, 1'b0, 6'd3, 11'h377, '0);
        check("R8 sel1", 32'(host_rdata), 32'h00FA);
        idle();

        // R9 device control store
        put(1'b0, 1'b1, 6'd1, 11'h00E, 16'h1102);
        check("R9 no tf_wr", 32'(tf_wr), 32'h0);
        check("R9 no card_reset", 32'(card_reset), 32'h0);
        idle();
        check("R9 dev_ctrl", 32'(dev_ctrl), 32'h02);

        // R11 odd byte latch
        put(1'b0, 1'b1, 6'd1, 11'h009, 16'h1234);
        check("R11 no tf_wr", 32'(tf_wr), 32'h0);
        idle();
        check("R11 latch1", 32'(byte_latch), 32'h34);
        check("R11 phase1", 32'(byte_phase), 32'h1);
        put(1'b0, 1'b1, 6'd1, 11'h009, 16'hABCD);
        idle();
        check("R11 latch2", 32'(byte_latch), 32'hCD);
        check("R11 phase2", 32'(byte_phase), 32'h0);
        put(1'b1, 1'b0, 6'd1, 11'h009, '0);
        check("R11 read zero", 32'(host_rdata), 32'h0);
        check("R11 read no tf_rd", 32'(tf_rd), 32'h0);
        idle();

        // R10 soft reset through device control
        put(1'b0, 1'b1, 6'd1, 11'h009, 16'h0077);
        idle();
        put(1'b0, 1'b1, 6'd2, 11'h3F6, 16'h0006);
        check("R10 card_reset pulse", 32'(card_reset), 32'h1);
        idle();
        check("R10 card_reset drop", 32'(card_reset), 32'h0);
        check("R10 dev_ctrl", 32'(dev_ctrl), 32'h0);
        check("R10 latch", 32'(byte_latch), 32'h0);
        check("R10 phase", 32'(byte_phase), 32'h0);

        // R12 power-down wake
        pwrdn_flag = 1'b1;
        put(1'b0, 1'b1, 6'd1, 11'h007, 16'h00EC);
        check("R12 pwrdn_clr", 32'(pwrdn_clr), 32'h1);
        check("R12 rdy_set", 32'(rdy_set), 32'h1);
        check("R6 tf_wr", 32'(tf_wr), 32'h1);
        check("R6 tf_off", 32'(tf_off), 32'h7);
        check("R6 tf_wdata", 32'(tf_wdata), 32'h00EC);
        idle();
        put(1'b0, 1'b1, 6'd0, 11'h500, 16'hBEEF);
        check("R12 data no wake", 32'(pwrdn_clr), 32'h0);
        check("R6 data tf_wr", 32'(tf_wr), 32'h1);
        check("R6 data tf_off", 32'(tf_off), 32'h0);
        idle();
        put(1'b0, 1'b1, 6'd1, 11'h00D, 16'h0003);
        check("R12 feat no wake", 32'(rdy_set), 32'h0);
        check("R6 feat tf_off", 32'(tf_off), 32'h1);
        idle();
        put(1'b0, 1'b1, 6'd3, 11'h377, 16'h00A0);
        check("R12 0xF wake", 32'(pwrdn_clr), 32'h1);
        check("R6 0xF tf_off", 32'(tf_off), 32'hF);
        idle();
        pwrdn_flag = 1'b0;
        put(1'b0, 1'b1, 6'd1, 11'h003, 16'h0001);
        check("R12 awake no pulse", 32'(pwrdn_clr), 32'h0);
        idle();

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule